// File: doc/BRIEF.md
# Abort Tracking Instruction Pipeline

This block follows failed memory transactions through a short in-order fetch/decode/execute pipeline. At every clock edge it looks at the bus abort line, but only when the current bus cycle is a real memory access. It sorts each abort by the kind of access that failed.

A failed data access produces a data-abort trap request on the next cycle. A failed opcode fetch is handled differently. It becomes a tag on the instruction slot that the fetch creates, and that tag moves forward each time the pipeline advances. A prefetch-abort trap request appears only when the tagged instruction completes in execute with its condition met. If a flush removes the instruction first, the tag is discarded and no trap is raised.

The surrounding core supplies the pipeline advance strobe, the flush and the execute-condition result. It takes the two one-cycle trap requests as its only outputs.

Top module: `abort_pipe_tracker`

## Requirements
- R1: Reset is synchronous and active low. After reset, both trap requests are low and every pipeline slot is empty, so advancing with a passing condition raises no prefetch abort.
- R2: In a memory cycle (`cyc_type` 00 non-sequential or 01 sequential) with `acc_fetch`=0 (data access) and `bus_abort`=1 at a clock edge, `dabt_req` is high for the single cycle after that edge.
- R3: `bus_abort` has no effect during internal (`cyc_type` 10) or coprocessor (`cyc_type` 11) cycles. No data abort is raised, and no instruction slot or tag is created.
- R4: When a memory cycle with `acc_fetch`=1 and `advance`=1 is sampled, a valid slot enters fetch, and its tag equals `bus_abort`. After PIPE_DEPTH-1 further advancing edges the slot sits in execute. At the next advancing edge with `cond_pass`=1, a tagged slot makes `pabt_req` high for one cycle. A fetch abort never raises `dabt_req`.
- R5: A tagged slot that leaves execute on an advancing edge with `cond_pass`=0 raises no prefetch abort, and its tag is gone afterwards.
- R6: `flush` empties every stage except execute. With `advance`=1 it also makes execute empty and inserts no new fetch slot; the instruction that was in execute still completes at that edge.
- R7: If a data abort and a prefetch abort arise at the same edge, only `dabt_req` is raised and the prefetch request is dropped.
- R8: While `advance`=0 and `flush`=0, all slots hold and `pabt_req` stays low.
- R9: A fetch completed without abort never produces `pabt_req`, even when it executes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_abort | input | 1 | Memory transaction failed, sampled at the clock edge |
| acc_fetch | input | 1 | 1 = opcode fetch, 0 = data access |
| cyc_type | input | 2 | 00 non-sequential, 01 sequential, 10 internal, 11 coprocessor |
| advance | input | 1 | All pipeline stages move forward one place |
| flush | input | 1 | Discard fetch and decode contents |
| cond_pass | input | 1 | Instruction in execute meets its condition |
| dabt_req | output | 1 | Data-abort trap request, one cycle |
| pabt_req | output | 1 | Prefetch-abort trap request, one cycle |

## Verification
The assertions assume that `cyc_type`, `acc_fetch`, `advance`, `flush` and `cond_pass` are known and stable around every sampling edge once reset is released. They also assume that `cond_pass` matters only on edges where execute is advancing.

The stimulus changes inputs only on the falling clock edge, and it holds reset low from time zero. It covers every combination of cycle type, access kind and abort, both through directed sequences that place a tagged slot in execute and through a long pseudo-random sweep. The bench compares that sweep against an arithmetic slot model it keeps itself.

// File: rtl/abt_pkg.sv
// Package: shared encodings for the abort tracking pipeline.
// Assumes two-bit bus cycle codes; bit 1 set marks a non-memory cycle.
package abt_pkg;

    typedef enum logic [1:0] {
        CYC_NSEQ  = 2'b00,
        CYC_SEQ   = 2'b01,
        CYC_INT   = 2'b10,
        CYC_COPRO = 2'b11
    } cyc_e;

    // One pipeline slot: occupancy and pending fetch-abort tag.
    typedef struct packed {
        logic valid;
        logic tag;
    } slot_t;

endpackage

// File: rtl/abt_bus_sampler.sv
// Module: classifies the bus cycle seen at the current edge.
// Assumes inputs are valid at the clock edge; purely combinational.
module abt_bus_sampler
    import abt_pkg::*;
(
    input  logic        bus_abort,
    input  logic        acc_fetch,
    input  logic [1:0]  cyc_type,
    output logic        data_abt,
    output slot_t       fetch_slot
);

    logic mem_cycle;

    // Decode memory cycles and split the abort by access kind.
    always_comb begin
        mem_cycle        = (cyc_type == CYC_NSEQ) || (cyc_type == CYC_SEQ);
        data_abt         = mem_cycle && !acc_fetch && bus_abort;
        fetch_slot.valid = mem_cycle && acc_fetch;
        fetch_slot.tag   = mem_cycle && acc_fetch && bus_abort;
    end

endmodule

// File: rtl/abt_pipe_stage.sv
// Module: one pipeline slot register holding valid bit and abort tag.
// Assumes FLUSHABLE=1 for fetch/decode, 0 for execute.
module abt_pipe_stage
    import abt_pkg::*;
#(
    parameter bit FLUSHABLE = 1'b1
)(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   advance,
    input  logic   flush,
    input  slot_t  in_slot,
    output slot_t  out_slot
);

    slot_t slot_q;

    // Load on advance (empty when flushing), clear on a lone flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (advance)
            slot_q <= flush ? slot_t'('0) : in_slot;
        else if (flush && FLUSHABLE)
            slot_q <= '0;
    end

    assign out_slot = slot_q;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !flush) |=> $stable(slot_q));

    p_no_orphan_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.tag |-> slot_q.valid);

    generate
        if (FLUSHABLE) begin : g_flush_chk
            p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                flush |=> !slot_q.valid);
        end else begin : g_exec_chk
            p_flush_adv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (flush && advance) |=> !slot_q.valid);
        end
    endgenerate

endmodule

// File: rtl/abt_pipe_chain.sv
// Module: chain of PIPE_DEPTH slots; index 0 is fetch, last is execute.
// Assumes PIPE_DEPTH >= 2; all stages share one advance strobe.
module abt_pipe_chain
    import abt_pkg::*;
#(
    parameter int PIPE_DEPTH = 3
)(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   advance,
    input  logic   flush,
    input  slot_t  new_slot,
    output slot_t  exec_slot
);

    localparam int LAST = PIPE_DEPTH - 1;

    slot_t chain [PIPE_DEPTH+1];

    assign chain[0] = new_slot;

    genvar gi;
    generate
        for (gi = 0; gi < PIPE_DEPTH; gi++) begin : g_stage
            abt_pipe_stage #(
                .FLUSHABLE (gi != LAST)
            ) i_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .advance  (advance),
                .flush    (flush),
                .in_slot  (chain[gi]),
                .out_slot (chain[gi+1])
            );
        end
    endgenerate

    assign exec_slot = chain[PIPE_DEPTH];

endmodule

// File: rtl/abt_trap_gen.sv
// Module: turns a data abort or a completed tagged instruction into
// registered one-cycle trap requests, data abort having priority.
// Assumes exec_slot is the slot that completes on an advancing edge.
module abt_trap_gen
    import abt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   data_abt,
    input  logic   advance,
    input  logic   cond_pass,
    input  slot_t  exec_slot,
    output logic   dabt_req,
    output logic   pabt_req
);

    logic exec_fault;

    // A tagged instruction executes when it completes with its condition met.
    always_comb begin
        exec_fault = advance && cond_pass && exec_slot.valid && exec_slot.tag;
    end

    // Register the requests; a data abort masks the prefetch request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dabt_req <= 1'b0;
            pabt_req <= 1'b0;
        end else begin
            dabt_req <= data_abt;
            pabt_req <= exec_fault && !data_abt;
        end
    end

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dabt_req && pabt_req));

    p_data_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_abt |=> !pabt_req);

endmodule

// File: rtl/abort_pipe_tracker.sv
// Module: top of the abort tracking pipeline. Samples the bus abort,
// raises data aborts at once and carries fetch aborts to execute.
// Assumes one bus cycle per clock and synchronous active-low reset.
module abort_pipe_tracker
    import abt_pkg::*;
#(
    parameter int PIPE_DEPTH = 3
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_abort,
    input  logic        acc_fetch,
    input  logic [1:0]  cyc_type,
    input  logic        advance,
    input  logic        flush,
    input  logic        cond_pass,
    output logic        dabt_req,
    output logic        pabt_req
);

    logic  data_abt;
    slot_t fetch_slot;
    slot_t exec_slot;

    abt_bus_sampler i_sampler (
        .bus_abort  (bus_abort),
        .acc_fetch  (acc_fetch),
        .cyc_type   (cyc_type),
        .data_abt   (data_abt),
        .fetch_slot (fetch_slot)
    );

    abt_pipe_chain #(
        .PIPE_DEPTH (PIPE_DEPTH)
    ) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .flush     (flush),
        .new_slot  (fetch_slot),
        .exec_slot (exec_slot)
    );

    abt_trap_gen i_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_abt  (data_abt),
        .advance   (advance),
        .cond_pass (cond_pass),
        .exec_slot (exec_slot),
        .dabt_req  (dabt_req),
        .pabt_req  (pabt_req)
    );

    p_dabt_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dabt_req |-> $past(bus_abort && !acc_fetch && !cyc_type[1]));

    p_ignore_nonmem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_type[1] |=> !dabt_req);

    p_pabt_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pabt_req |-> $past(advance && cond_pass));

    p_cond_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !cond_pass) |=> !pabt_req);

    p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !pabt_req);

endmodule

// File: tb/test_abort_pipe_tracker.sv
`timescale 1ns/1ps
module test_abort_pipe_tracker;

    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_abort = 1'b0;
    logic       acc_fetch = 1'b0;
    logic [1:0] cyc_type = 2'b10;
    logic       advance = 1'b0;
    logic       flush = 1'b0;
    logic       cond_pass = 1'b0;
    logic       dabt_req;
    logic       pabt_req;

    int checks = 0;
    int errors = 0;

    // bench slot model: valid and tag per stage
    bit mv [D];
    bit mt [D];

    always #5 clk = ~clk;

    abort_pipe_tracker #(.PIPE_DEPTH(D)) i_abort_pipe_tracker (
        .clk(clk), .rst_n(rst_n), .bus_abort(bus_abort), .acc_fetch(acc_fetch),
        .cyc_type(cyc_type), .advance(advance), .flush(flush),
        .cond_pass(cond_pass), .dabt_req(dabt_req), .pabt_req(pabt_req)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < D; i++) begin
            mv[i] = 0;
            mt[i] = 0;
        end
    endtask

    // One clock: drive at falling edge, update model, compare after the edge.
    task automatic step(input bit ab, input bit fe, input bit [1:0] cy,
                        input bit ad, input bit fl, input bit cd,
                        input bit ed, input bit ep, input string tag, input bit use_model);
        bit mem, dn, fire;
        mem  = (cy[1] == 1'b0);
        dn   = mem && !fe && ab;
        fire = ad && cd && mv[D-1] && mt[D-1] && !dn;
        if (ad) begin
            for (int i = D-1; i > 0; i--) begin
                mv[i] = fl ? 1'b0 : mv[i-1];
                mt[i] = fl ? 1'b0 : mt[i-1];
            end
            mv[0] = fl ? 1'b0 : (mem && fe);
            mt[0] = fl ? 1'b0 : (mem && fe && ab);
        end else if (fl) begin
            for (int i = 0; i < D-1; i++) begin
                mv[i] = 0;
                mt[i] = 0;
            end
        end
        if (use_model) begin
            ed = dn;
            ep = fire;
        end
        bus_abort = ab; acc_fetch = fe; cyc_type = cy;
        advance = ad; flush = fl; cond_pass = cd;
        @(posedge clk);
        @(negedge clk);
        chk(dabt_req, ed, tag, "dabt_req");
        chk(pabt_req, ep, tag, "pabt_req");
    endtask

    // Place a tagged instruction in execute: aborted fetch then D-1 clean fetches.
    task automatic load_tagged(input string tag);
        step(1, 1, 2'b00, 1, 0, 0, 0, 0, tag, 0);
        for (int i = 0; i < D-1; i++)
            step(0, 1, 2'b01, 1, 0, 0, 0, 0, tag, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dabt_req, 0, "R1", "reset dabt_req");
        chk(pabt_req, 0, "R1", "reset pabt_req");
        rst_n = 1'b1;
        // R1: empty pipeline executes nothing tagged
        for (int i = 0; i < D+1; i++)
            step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R1", 0);

        // R2: data abort in both memory cycle types, one-cycle pulse
        step(1, 0, 2'b00, 0, 0, 0, 1, 0, "R2", 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, "R2", 0);
        step(1, 0, 2'b01, 0, 0, 0, 1, 0, "R2", 0);
        step(0, 0, 2'b10, 0, 0, 0, 0, 0, "R2", 0);

        // R3: abort ignored in internal and coprocessor cycles, both access kinds
        for (int c = 2; c < 4; c++)
            for (int f = 0; f < 2; f++)
                step(1, f[0], c[1:0], 1, 0, 0, 0, 0, "R3", 0);
        for (int i = 0; i < D+1; i++)
            step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R3", 0);

        // R4: tagged fetch reaches execute and raises pabt_req once
        load_tagged("R4");
        step(0, 0, 2'b10, 1, 0, 1, 0, 1, "R4", 0);
        step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R4", 0);

        // R9: clean fetches never trap
        for (int i = 0; i < D+2; i++)
            step(0, 1, 2'b00, 1, 0, 1, 0, 0, "R9", 0);

        // R5: condition fails, tag leaves without trap
        load_tagged("R5");
        step(0, 0, 2'b10, 1, 0, 0, 0, 0, "R5", 0);
        step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R5", 0);

        // R6: lone flush drops tags in fetch and decode
        step(1, 1, 2'b00, 1, 0, 0, 0, 0, "R6", 0);
        step(1, 1, 2'b00, 1, 0, 0, 0, 0, "R6", 0);
        step(0, 0, 2'b10, 0, 1, 0, 0, 0, "R6", 0);
        for (int i = 0; i < D+1; i++)
            step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R6", 0);
        // R6: flush with advance lets execute complete, then empties it
        load_tagged("R6");
        step(1, 1, 2'b00, 1, 1, 1, 0, 1, "R6", 0);
        for (int i = 0; i < D+1; i++)
            step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R6", 0);

        // R7: data abort at the completing edge wins
        load_tagged("R7");
        step(1, 0, 2'b01, 1, 0, 1, 1, 0, "R7", 0);
        step(0, 0, 2'b10, 1, 0, 1, 0, 0, "R7", 0);

        // R8: stall holds the tag, trap follows the later advance
        load_tagged("R8");
        for (int i = 0; i < 4; i++)
            step(0, 0, 2'b10, 0, 0, 1, 0, 0, "R8", 0);
        step(0, 0, 2'b10, 1, 0, 1, 0, 1, "R8", 0);

        // R2 R4 R6 R7: pseudo-random sweep against the bench model
        begin
            logic [15:0] lf = 16'hACE1;
            for (int n = 0; n < 4000; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] & lf[7], lf[1] | lf[8], lf[3:2], lf[4] | lf[9], lf[5] & lf[6] & lf[11],
                     lf[10] | lf[12], 0, 0, "R4", 1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule